// File: doc/BRIEF.md
# Workload Classifier and Cluster Power-Gate Controller

This block counts hardware events over a programmable measurement window and sorts the running workload into one of four classes: low activity, compute-bound, mixed compute and memory, and memory-bound. Four events are counted: a reference time base tick, core clock cycles in which the core clock is enabled, retired instructions, and memory accesses that reach at least the level-1 data cache. From the window totals the block forms a utilisation figure (core cycles per reference tick) and a memory-adjusted IPC normalised to a programmable peak IPC. All threshold tests are done by cross-multiplying against Q0.8 constants, so no divider is needed.

Each class maps to a fixed decision for a big cluster and a little cluster. The decision is a power-gate enable per core plus a single minimum/maximum frequency request. Core 0 of the little cluster hosts the operating system and is never gated. The class, gate vectors and frequency request change only at the end of a window. A one-cycle strobe marks each new decision. The power switch network, the voltage regulators and the software scheduler sit outside this block and act on its outputs.

Top module: `wlc_ctrl`

## Requirements
- R1: A window closes in the cycle where `ref_tick_i` is high and the count of reference ticks in the window, including that tick, is at least `win_len_i`. A value of 0 is treated as 1. Events in the closing cycle belong to the closing window, and all four counts restart from zero in the next cycle.
- R2: On the clock edge at the end of the closing cycle, `class_o`, `freq_max_o`, `big_pg_o` and `little_pg_o` load the new decision, and `valid_o` is high for the following cycle only. In any cycle where `valid_o` is low, those outputs keep their previous values.
- R3: In each cycle, each count grows by one when its input is high: `ref_tick_i`, `cyc_en_i`, `inst_ret_i` and `mem_acc_i`. A count that reaches its maximum stays there until the window closes.
- R4: Let C be the core-cycle count and F the reference count. When C*256 <= 28*F, the class is 0 (low activity). This test takes priority over the IPC tests.
- R5: When C or F is zero at window close, the class is 0.
- R6: Let D be the retired count minus the memory count, floored at 0. Let M be `ipc_max_i`, with 0 treated as 1. The class is 1 (compute-bound) when D*256 >= 90*M*C.
- R7: Otherwise, the class is 2 (mixed) when D*256 >= 64*M*C.
- R8: Otherwise, the class is 3 (memory-bound). This includes every window in which memory accesses meet or exceed retired instructions.
- R9: Decision table. A 1 on a gate bit means gated. Class 0: `freq_max_o`=0, and all big and little gates are set. Class 1: `freq_max_o`=1, big running, little gated. Class 2: `freq_max_o`=0, and nothing is gated. Class 3: `freq_max_o`=1, big gated, little running.
- R10: `little_pg_o[0]` is always 0, whatever the class.
- R11: After reset, until the first window closes, `class_o`=2, `freq_max_o`=1, all gate bits are 0 and `valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Fixed-rate reference tick, one cycle wide |
| cyc_en_i | input | 1 | Core clock enabled this cycle |
| inst_ret_i | input | 1 | Instruction retired this cycle |
| mem_acc_i | input | 1 | Data memory access this cycle |
| win_len_i | input | WIN_W | Window length in reference ticks |
| ipc_max_i | input | IPC_W | Peak IPC used for normalisation |
| class_o | output | 2 | Workload class of the last window |
| freq_max_o | output | 1 | 1 requests maximum frequency, 0 minimum |
| big_pg_o | output | NB | Per-core gate enables, big cluster |
| little_pg_o | output | NL | Per-core gate enables, little cluster (bit 0 held low) |
| valid_o | output | 1 | One-cycle strobe marking a new decision |

## Verification
Two things collide in the closing cycle. The counters must fold the events of that same cycle into the totals being judged, and in the same cycle they must clear for the next window. The bench provokes this by placing events in the last cycle of shaped windows, by running back-to-back windows of length 0 and 1 that close on every tick, and by changing `win_len_i` in the middle of a window. A behavioural model tracks the totals and the decision every cycle and is compared with every output. Windows are also shaped so that the products land exactly on the 28, 90 and 64 boundaries, which separates `<=` from `<` and `>=` from `>`.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  typedef enum logic [1:0] {
    CLS_LOW = 2'd0,
    CLS_CPU = 2'd1,
    CLS_MIX = 2'd2,
    CLS_MEM = 2'd3
  } wl_class_e;

  localparam int unsigned NUM_EV  = 4;
  localparam int unsigned EV_REF  = 0;
  localparam int unsigned EV_CYC  = 1;
  localparam int unsigned EV_INST = 2;
  localparam int unsigned EV_MEM  = 3;

  // Q0.8 thresholds
  localparam int unsigned QSHIFT   = 8;
  localparam int unsigned THR_UTIL = 28;
  localparam int unsigned THR_HI   = 90;
  localparam int unsigned THR_LO   = 64;
endpackage

// File: rtl/wlc_sat_cnt.sv
module wlc_sat_cnt #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] tot_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && (cnt_q != MAX)) cnt_d = cnt_q + W'(1);
  end

  assign tot_o = cnt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> (cnt_q == MAX));

  p_clear_on_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/wlc_window.sv
module wlc_window
  import wlc_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned WIN_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_EV-1:0]             ev_i,
  input  logic [WIN_W-1:0]              win_len_i,
  output logic                          win_end_o,
  output logic [NUM_EV-1:0][CNT_W-1:0]  tot_o
);
  logic [CNT_W-1:0] eff_len;

  assign eff_len   = (win_len_i == '0) ? CNT_W'(1) : CNT_W'(win_len_i);
  assign win_end_o = ev_i[EV_REF] && (tot_o[EV_REF] >= eff_len);

  for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
    wlc_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (ev_i[g]),
      .clr_i  (win_end_o),
      .tot_o  (tot_o[g])
    );
  end
endmodule

// File: rtl/wlc_classify.sv
module wlc_classify
  import wlc_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned IPC_W = 4
) (
  input  logic [CNT_W-1:0] ref_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic [CNT_W-1:0] inst_i,
  input  logic [CNT_W-1:0] mem_i,
  input  logic [IPC_W-1:0] ipc_max_i,
  output wl_class_e        cls_o
);
  localparam int unsigned PW = CNT_W + IPC_W + 16;

  logic [PW-1:0] ref_w, cyc_w, diff_w, ipc_w, scale_w;
  logic          util_low, ipc_hi, ipc_lo;

  always_comb begin
    ref_w   = PW'(ref_i);
    cyc_w   = PW'(cyc_i);
    diff_w  = (inst_i > mem_i) ? PW'(inst_i - mem_i) : '0;
    ipc_w   = (ipc_max_i == '0) ? PW'(1) : PW'(ipc_max_i);
    scale_w = ipc_w * cyc_w;

    util_low = (cyc_w << QSHIFT) <= (ref_w * PW'(THR_UTIL));
    ipc_hi   = (diff_w << QSHIFT) >= (scale_w * PW'(THR_HI));
    ipc_lo   = (diff_w << QSHIFT) >= (scale_w * PW'(THR_LO));

    if (cyc_i == '0 || ref_i == '0) cls_o = CLS_LOW;
    else if (util_low)              cls_o = CLS_LOW;
    else if (ipc_hi)                cls_o = CLS_CPU;
    else if (ipc_lo)                cls_o = CLS_MIX;
    else                            cls_o = CLS_MEM;
  end
endmodule

// File: rtl/wlc_policy.sv
module wlc_policy
  import wlc_pkg::*;
#(
  parameter int unsigned NB = 4,
  parameter int unsigned NL = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  wl_class_e     cls_i,
  output logic [1:0]    class_o,
  output logic          freq_max_o,
  output logic [NB-1:0] big_pg_o,
  output logic [NL-1:0] little_pg_o,
  output logic          valid_o
);
  wl_class_e cls_q;
  logic      freq_q, big_g_q, lit_g_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q   <= CLS_MIX;
      freq_q  <= 1'b1;
      big_g_q <= 1'b0;
      lit_g_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= upd_i;
      if (upd_i) begin
        cls_q <= cls_i;
        unique case (cls_i)
          CLS_LOW: begin freq_q <= 1'b0; big_g_q <= 1'b1; lit_g_q <= 1'b1; end
          CLS_CPU: begin freq_q <= 1'b1; big_g_q <= 1'b0; lit_g_q <= 1'b1; end
          CLS_MIX: begin freq_q <= 1'b0; big_g_q <= 1'b0; lit_g_q <= 1'b0; end
          CLS_MEM: begin freq_q <= 1'b1; big_g_q <= 1'b1; lit_g_q <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  assign class_o    = cls_q;
  assign freq_max_o = freq_q;
  assign valid_o    = valid_q;
  assign big_pg_o   = {NB{big_g_q}};

  // core 0 of the little cluster runs the OS
  if (NL > 1) begin : g_lit_multi
    assign little_pg_o = {{(NL-1){lit_g_q}}, 1'b0};
  end else begin : g_lit_single
    assign little_pg_o = 1'b0;
  end

  p_os_core_on_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    little_pg_o[0] == 1'b0);

  p_hold_between_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(class_o) && $stable(freq_max_o) &&
                  $stable(big_pg_o) && $stable(little_pg_o)));
endmodule

// File: rtl/wlc_ctrl.sv
module wlc_ctrl
  import wlc_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned WIN_W = 16,
  parameter int unsigned IPC_W = 4,
  parameter int unsigned NB    = 4,
  parameter int unsigned NL    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             cyc_en_i,
  input  logic             inst_ret_i,
  input  logic             mem_acc_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [IPC_W-1:0] ipc_max_i,
  output logic [1:0]       class_o,
  output logic             freq_max_o,
  output logic [NB-1:0]    big_pg_o,
  output logic [NL-1:0]    little_pg_o,
  output logic             valid_o
);
  logic [NUM_EV-1:0]            ev;
  logic [NUM_EV-1:0][CNT_W-1:0] tot;
  logic                         win_end;
  wl_class_e                    cls;

  always_comb begin
    ev          = '0;
    ev[EV_REF]  = ref_tick_i;
    ev[EV_CYC]  = cyc_en_i;
    ev[EV_INST] = inst_ret_i;
    ev[EV_MEM]  = mem_acc_i;
  end

  wlc_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .win_len_i (win_len_i),
    .win_end_o (win_end),
    .tot_o     (tot)
  );

  wlc_classify #(.CNT_W(CNT_W), .IPC_W(IPC_W)) u_classify (
    .ref_i     (tot[EV_REF]),
    .cyc_i     (tot[EV_CYC]),
    .inst_i    (tot[EV_INST]),
    .mem_i     (tot[EV_MEM]),
    .ipc_max_i (ipc_max_i),
    .cls_o     (cls)
  );

  wlc_policy #(.NB(NB), .NL(NL)) u_policy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (win_end),
    .cls_i       (cls),
    .class_o     (class_o),
    .freq_max_o  (freq_max_o),
    .big_pg_o    (big_pg_o),
    .little_pg_o (little_pg_o),
    .valid_o     (valid_o)
  );

  p_zero_cyc_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end && tot[EV_CYC] == '0) |=> (class_o == 2'd0 && valid_o));
endmodule

// File: tb/wlc_ctrl_tb.sv
module wlc_ctrl_tb;
  localparam int NB = 4;
  localparam int NL = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_tick = 1'b0, cyc_en = 1'b0, inst = 1'b0, mem = 1'b0;
  logic [15:0] win_len = 16'd1;
  logic [3:0]  ipc_max = 4'd1;
  logic [1:0]  class_o;
  logic        freq_max_o, valid_o;
  logic [NB-1:0] big_pg_o;
  logic [NL-1:0] little_pg_o;

  int n_cmp = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wlc_ctrl #(.NB(NB), .NL(NL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_tick_i(ref_tick), .cyc_en_i(cyc_en),
    .inst_ret_i(inst), .mem_acc_i(mem), .win_len_i(win_len), .ipc_max_i(ipc_max),
    .class_o(class_o), .freq_max_o(freq_max_o), .big_pg_o(big_pg_o),
    .little_pg_o(little_pg_o), .valid_o(valid_o)
  );

  // reference model state
  longint m_ref, m_cyc, m_inst, m_mem;
  int     e_cls = 2;
  bit     e_freq = 1'b1, e_big = 1'b0, e_lit = 1'b0, e_valid = 1'b0, seen = 1'b0;
  string  e_tag = "R11";

  function automatic int model_cls(longint f, longint c, longint r, longint m,
                                   int ipc, output string tag);
    longint d, im;
    if (c == 0 || f == 0) begin tag = "R5"; return 0; end
    if (c * 256 <= 28 * f) begin tag = "R4"; return 0; end
    d  = (r > m) ? r - m : 0;
    im = (ipc == 0) ? 1 : ipc;
    if (d * 256 >= 90 * im * c) begin tag = "R6"; return 1; end
    if (d * 256 >= 64 * im * c) begin tag = "R7"; return 2; end
    tag = "R8";
    return 3;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ref = 0; m_cyc = 0; m_inst = 0; m_mem = 0;
      e_cls = 2; e_freq = 1'b1; e_big = 1'b0; e_lit = 1'b0;
      e_valid = 1'b0; seen = 1'b0; e_tag = "R11";
    end else begin
      // R3: per-cycle accumulation; R1: closing cycle included
      m_ref  += ref_tick;
      m_cyc  += cyc_en;
      m_inst += inst;
      m_mem  += mem;
      e_valid = 1'b0;
      if (ref_tick && m_ref >= ((win_len == 0) ? 1 : longint'(win_len))) begin
        e_cls = model_cls(m_ref, m_cyc, m_inst, m_mem, int'(ipc_max), e_tag);
        // R9 decision table
        case (e_cls)
          0: begin e_freq = 1'b0; e_big = 1'b1; e_lit = 1'b1; end
          1: begin e_freq = 1'b1; e_big = 1'b0; e_lit = 1'b1; end
          2: begin e_freq = 1'b0; e_big = 1'b0; e_lit = 1'b0; end
          default: begin e_freq = 1'b1; e_big = 1'b1; e_lit = 1'b0; end
        endcase
        e_valid = 1'b1; seen = 1'b1;
        m_ref = 0; m_cyc = 0; m_inst = 0; m_mem = 0;
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s @%0t: actual %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [NL-1:0] lit_exp;
      lit_exp = e_lit ? {{(NL-1){1'b1}}, 1'b0} : '0;
      chk(seen ? "R1/R2" : "R11", "valid_o", valid_o, e_valid);
      chk(seen ? e_tag : "R11", "class_o", class_o, e_cls);
      chk(seen ? "R9" : "R11", "freq_max_o", freq_max_o, e_freq);
      chk(seen ? "R9" : "R11", "big_pg_o", big_pg_o, e_big ? {NB{1'b1}} : '0);
      chk(seen ? "R9" : "R11", "little_pg_o", little_pg_o, lit_exp);
      chk("R10", "little_pg_o[0]", little_pg_o[0], 0);
    end
  end

  // one window of len ticks, one tick per cycle; events packed at the front
  task automatic win(int len, int wl, int ncyc, int ninst, int nmem, int ipc);
    win_len = 16'(wl);
    ipc_max = 4'(ipc);
    for (int i = 0; i < len; i++) begin
      ref_tick = 1'b1;
      cyc_en   = (i < ncyc);
      inst     = (i < ninst);
      mem      = (i < nmem);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;
    win(8, 8, 8, 8, 0, 1);          // R6 plain compute-bound
    win(64, 64, 7, 0, 0, 1);        // R4 boundary equal -> low
    win(64, 64, 8, 8, 0, 1);        // R4 just above -> R6
    win(128, 128, 128, 45, 0, 1);   // R6 boundary
    win(128, 128, 128, 44, 0, 1);   // R7
    win(128, 128, 128, 32, 0, 1);   // R7 boundary
    win(128, 128, 128, 31, 0, 1);   // R8
    win(16, 16, 16, 4, 10, 1);      // R8 mem exceeds retired
    win(16, 16, 0, 5, 0, 1);        // R5 zero cycles
    win(128, 128, 128, 45, 0, 0);   // R6 ipc_max 0 as 1
    win(128, 128, 128, 45, 0, 2);   // R8 with ipc_max 2
    win(6, 0, 6, 6, 0, 1);          // R1 length 0 closes every tick
    win(6, 1, 6, 0, 6, 1);          // R1 length 1
    // random phase: sparse ticks, mid-window length changes
    ref_tick = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      if (i % 97 == 0) win_len = 16'($urandom_range(0, 12));
      if (i % 500 == 0) ipc_max = 4'($urandom_range(0, 3));
      ref_tick = ($urandom_range(0, 2) == 0);
      cyc_en   = ($urandom_range(0, 99) < ((i / 1000) * 18 + 5));
      inst     = ($urandom_range(0, 3) != 0);
      mem      = ($urandom_range(0, 99) < ((i / 750) * 12));
      @(posedge clk); #1;
    end
    ref_tick = 1'b0; cyc_en = 1'b0; inst = 1'b0; mem = 1'b0;
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule